// File: doc/BRIEF.md
# Spread Spectrum Frequency Offset Generator

This block produces a slowly changing signed frequency-offset word. The word steers a digitally controlled clock synthesizer, such as a fractional divider or a numerically controlled oscillator. Sweeping the synthesized clock across a narrow band spreads its spectral energy, which lowers the peak emission. The offset is given in units of 0.01 % of the nominal frequency.

The sweep follows a symmetric triangle over one modulation period of 2^PER_LOG2 clock cycles. The default is 1024 cycles, roughly one thousandth of the clock rate. A 3-bit width select and a range input choose the width and the mode. Down-spread keeps the clock at or below nominal. Center-spread places the band about nominal. Even select codes turn spreading off. An active-low enable forces the offset to zero; at integration, an undriven enable is tied low so that spreading is on by default. A stop input freezes the sweep and raises a gate output that holds the downstream clock low.

The offset, sweep flag and gate are control levels that are valid on every cycle. They carry no valid/ready handshake, and back-pressure does not apply.

Top module: `ssc_offset_gen`

## Requirements
- R1: When select bit 0 is 0 (an even code), the offset is 0 on every cycle of the period.
- R2: With the range input at 0, the width select codes map as follows: 3'b001 is down-spread with span 125, 3'b011 is center-spread with span 125, 3'b101 is down-spread with span 250, and 3'b111 is center-spread with span 250. In every case, bit 1 selects center mode and bit 2 doubles the span.
- R3: With the range input at 1, the same codes give four times the span: 500, 500, 1000 and 1000, in the same down/center pattern.
- R4: In down-spread mode, the offset equals v - span. It therefore stays between -span and 0 and is never positive.
- R5: In center-spread mode, the offset equals v - ceil(span/2), which is never above +span/2.
- R6: With phase p in 0..N-1 and H = N/2, define tri = p when p < H and tri = N - p otherwise. Then v = floor(span*tri/H). The sweep flag is 1 exactly when p < H.
- R7: The phase starts at 0, advances by one on each clock, and wraps from N-1 to 0. The period N is 2^PER_LOG2, which is 1024 by default.
- R8: While the active-low enable is high, the offset is 0 in the same cycle, and the phase keeps advancing. While it is low, the offset follows R4 to R6.
- R9: While stop is high, the phase is frozen, so the offset and sweep flag hold their values. The gate output equals the value stop had at the previous clock edge.
- R10: A new width select or range value is taken only on the clock edge where the phase wraps from N-1 to 0, or during reset. Until then, the current sweep continues unchanged.
- R11: A synchronous active-high reset sets the phase to 0, samples the configuration, and clears the gate. The first offset after reset is the mode's low limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wsel_i | input | 3 | Width select: bit0 spread, bit1 center, bit2 double |
| wide_i | input | 1 | Range input, 1 gives the four-times table |
| spread_n_i | input | 1 | Spread enable, active low |
| stop_i | input | 1 | Stop: freeze the sweep and gate the clock |
| offset_o | output | OFF_W (12) | Signed offset in 0.01 % units |
| sweep_up_o | output | 1 | 1 during the rising half of the sweep |
| gate_o | output | 1 | Forces the downstream clock low |

## Verification
The hardest cases to reach are those that depend on the position within the period. These are a configuration change made in the middle of a sweep, and a stop that arrives on the final phase just before the wrap. The bench uses a 64-cycle period and keeps its own phase count. It changes the select inputs several cycles into a sweep, and it raises stop exactly at phase N-1 while a different configuration is pending. The old sweep must run to its end, and the new configuration may load only on the first unstopped wrap.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int SPAN_W = 11;

  typedef struct packed {
    logic [SPAN_W-1:0] span;
    logic              center;
  } ssc_cfg_t;

  // bit0 enables the sweep, bit1 picks center mode, bit2 and range scale the span
  function automatic ssc_cfg_t decode_cfg(input logic [2:0] sel, input logic wide,
                                          input int unsigned base);
    ssc_cfg_t c;
    int unsigned sh;
    sh = {30'd0, wide, sel[2]};
    c.center = sel[1];
    c.span   = sel[0] ? SPAN_W'(base << sh) : '0;
    return c;
  endfunction
endpackage

// File: rtl/ssc_phase.sv
module ssc_phase #(
  parameter int PER_LOG2 = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stop_i,
  output logic [PER_LOG2-1:0] phase_o,
  output logic                wrap_o,
  output logic                sweep_up_o
);
  localparam logic [PER_LOG2-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst)          phase_o <= '0;
    else if (!stop_i) phase_o <= phase_o + 1'b1;
  end

  assign wrap_o     = !stop_i && (phase_o == LAST);
  assign sweep_up_o = ~phase_o[PER_LOG2-1];

  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> $stable(phase_o)); // R9
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (phase_o == LAST && !stop_i) |=> (phase_o == '0)); // R7
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase_o != LAST && !stop_i) |=> (phase_o == $past(phase_o) + 1'b1)); // R7
endmodule

// File: rtl/ssc_cfg_reg.sv
module ssc_cfg_reg
  import ssc_pkg::*;
#(
  parameter int unsigned BASE_SPAN = 125
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [2:0] wsel_i,
  input  logic       wide_i,
  output ssc_cfg_t   cfg_o
);
  always_ff @(posedge clk) begin
    if (rst || load_i) cfg_o <= decode_cfg(wsel_i, wide_i, BASE_SPAN);
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(cfg_o)); // R10
endmodule

// File: rtl/ssc_shape.sv
module ssc_shape
  import ssc_pkg::*;
#(
  parameter int PER_LOG2 = 10,
  parameter int OFF_W    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PER_LOG2-1:0] phase_i,
  input  ssc_cfg_t            cfg_i,
  input  logic                spread_n_i,
  output logic [OFF_W-1:0]    offset_o
);
  localparam int PROD_W = SPAN_W + PER_LOG2;
  localparam logic [PER_LOG2:0] FULL = (PER_LOG2+1)'(1) << PER_LOG2;

  logic [PER_LOG2:0]   down_leg;
  logic [PER_LOG2-1:0] tri_v;
  logic [PROD_W-1:0]   prod;
  logic [SPAN_W-1:0]   ramp;
  logic [SPAN_W-1:0]   low_lim;

  always_comb begin
    down_leg = FULL - {1'b0, phase_i};
    tri_v    = phase_i[PER_LOG2-1] ? down_leg[PER_LOG2-1:0] : phase_i;
    prod     = PROD_W'(cfg_i.span) * PROD_W'(tri_v);
    ramp     = SPAN_W'(prod >> (PER_LOG2 - 1));
    low_lim  = cfg_i.center ? SPAN_W'((cfg_i.span + 1'b1) >> 1) : cfg_i.span;
    if (spread_n_i) offset_o = '0;
    else            offset_o = OFF_W'(ramp) - OFF_W'(low_lim);
  end

  AST_DOWN_NONPOS: assert property (@(posedge clk) disable iff (rst)
    !cfg_i.center |-> ($signed(offset_o) <= 0 &&
                       $signed(offset_o) >= -$signed({1'b0, cfg_i.span}))); // R4
  AST_CENTER_TOP: assert property (@(posedge clk) disable iff (rst)
    cfg_i.center |-> ($signed(offset_o) <= $signed({2'b0, cfg_i.span[SPAN_W-1:1]}))); // R5
endmodule

// File: rtl/ssc_offset_gen.sv
module ssc_offset_gen
  import ssc_pkg::*;
#(
  parameter int          PER_LOG2  = 10,
  parameter int          OFF_W     = 12,
  parameter int unsigned BASE_SPAN = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       wsel_i,
  input  logic             wide_i,
  input  logic             spread_n_i,
  input  logic             stop_i,
  output logic [OFF_W-1:0] offset_o,
  output logic             sweep_up_o,
  output logic             gate_o
);
  logic [PER_LOG2-1:0] phase;
  logic                wrap;
  ssc_cfg_t            cfg;

  ssc_phase #(.PER_LOG2(PER_LOG2)) phase_u (
    .clk(clk), .rst(rst), .stop_i(stop_i),
    .phase_o(phase), .wrap_o(wrap), .sweep_up_o(sweep_up_o)
  );

  ssc_cfg_reg #(.BASE_SPAN(BASE_SPAN)) cfg_u (
    .clk(clk), .rst(rst), .load_i(wrap),
    .wsel_i(wsel_i), .wide_i(wide_i), .cfg_o(cfg)
  );

  ssc_shape #(.PER_LOG2(PER_LOG2), .OFF_W(OFF_W)) shape_u (
    .clk(clk), .rst(rst), .phase_i(phase), .cfg_i(cfg),
    .spread_n_i(spread_n_i), .offset_o(offset_o)
  );

  always_ff @(posedge clk) begin
    if (rst) gate_o <= 1'b0;
    else     gate_o <= stop_i;
  end

  AST_GATE_ON: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> gate_o); // R9
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !stop_i |=> !gate_o); // R9
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stop_i && $stable(spread_n_i)) |=> $stable(offset_o)); // R9
endmodule

// File: tb/ssc_offset_gen_tb.sv
module ssc_offset_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 6;
  localparam int N  = 1 << PL;
  localparam int H  = N / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  wsel = 3'd0;
  logic        wide = 1'b0;
  logic        spread_n = 1'b0;
  logic        stop = 1'b0;
  logic [11:0] offset;
  logic        sweep_up;
  logic        gate;

  ssc_offset_gen #(.PER_LOG2(PL), .OFF_W(12), .BASE_SPAN(125)) dut_i (
    .clk(clk), .rst(rst), .wsel_i(wsel), .wide_i(wide), .spread_n_i(spread_n),
    .stop_i(stop), .offset_o(offset), .sweep_up_o(sweep_up), .gate_o(gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  int m_span = 0;
  bit m_center = 1'b0;
  bit m_gate = 1'b0;

  function automatic int span_of(input logic [2:0] s, input logic w);
    int sh;
    sh = 2 * int'(w) + int'(s[2]);
    return s[0] ? (125 << sh) : 0;
  endfunction

  function automatic int exp_off();
    int tri_v;
    int v;
    if (spread_n) return 0;
    tri_v = (ph < H) ? ph : N - ph;
    v = (m_span * tri_v) / H;
    return m_center ? v - (m_span + 1) / 2 : v - m_span;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (phase %0d)", req, act, exp, ph);
    end
  endtask

  task automatic load_cfg();
    m_span   = span_of(wsel, wide);
    m_center = wsel[1];
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin
      ph = 0; load_cfg(); m_gate = 1'b0;
    end else begin
      m_gate = stop;
      if (!stop) begin
        if (ph == N - 1) begin ph = 0; load_cfg(); end
        else ph++;
      end
    end
    @(negedge clk);
  endtask

  task automatic verify(input string req);
    check(req, int'($signed(offset)), exp_off());
    check({req, " R6 sweep"}, int'(sweep_up), int'(ph < H));
    check("R9 gate", int'(gate), int'(m_gate));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    @(negedge clk);
    tick();
    rst = 1'b0;
    // exhaustive sweep over range and width select: R1 R2 R3 R4 R5 R6 R7 R11
    for (int w = 0; w < 2; w++) begin
      for (int s = 0; s < 8; s++) begin
        wide = w[0]; wsel = s[2:0]; rst = 1'b1;
        tick();
        rst = 1'b0;
        verify("R11 start");
        if (!s[0])     tag = "R1 even";
        else if (w==0) tag = s[1] ? "R2 R5 R7" : "R2 R4 R7";
        else           tag = s[1] ? "R3 R5 R7" : "R3 R4 R7";
        for (int k = 0; k < 2 * N; k++) begin
          tick();
          verify(tag);
        end
      end
    end
    // R10: change config mid-sweep, takes effect only at wrap
    wide = 1'b0; wsel = 3'b001; rst = 1'b1; tick(); rst = 1'b0;
    for (int k = 0; k < 10; k++) begin tick(); verify("R10 before"); end
    wide = 1'b1; wsel = 3'b111;
    for (int k = 0; k < N + 5; k++) begin tick(); verify("R10 pending"); end
    // R9: stop mid-sweep then stop on the final phase with a pending change
    stop = 1'b1;
    for (int k = 0; k < 6; k++) begin tick(); verify("R9 frozen"); end
    stop = 1'b0;
    while (ph != N - 1) begin tick(); verify("R9 run"); end
    wsel = 3'b101; wide = 1'b1;
    stop = 1'b1;
    for (int k = 0; k < 4; k++) begin tick(); verify("R9 R10 stop at last"); end
    stop = 1'b0;
    for (int k = 0; k < N; k++) begin tick(); verify("R9 R10 resume"); end
    // R8: disable spreading, phase keeps running
    spread_n = 1'b1;
    #1;
    check("R8 immediate", int'($signed(offset)), 0);
    for (int k = 0; k < 20; k++) begin tick(); verify("R8 off"); end
    spread_n = 1'b0;
    #1;
    check("R8 resume", int'($signed(offset)), exp_off());
    for (int k = 0; k < N; k++) begin tick(); verify("R8 on"); end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule